// File: doc/BRIEF.md
# Convolution Address Sequencer

This block sequences a 3x3 convolution over a square pixel buffer whose side is 16 by default. While the mode input is low the block sits idle and the buffer is written from outside. While it is high the block walks every output pixel, Y in the inner loop and X in the outer loop. For each output pixel it issues nine tap cycles. In each tap cycle it presents a coefficient address for the kernel ROM and a clamped X/Y read address for the pixel buffer, and it holds the operate strobe high for the arithmetic unit.

After the ninth tap the strobe drops. The block then waits until the arithmetic unit reports completion with its ready and set lines both high, and only then starts the next output pixel. This keeps the pixel stream and the coefficient stream in step. When the last pixel has been acknowledged, a done flag rises and stays up until the mode input falls.

Top module: `conv_addr_seq`

## Requirements
- R1: While `conv_en` is low, `op` and `done` are low on the next cycle and all counters clear. This includes dropping `conv_en` in the middle of a pixel. When `conv_en` is next seen high, `op` rises one cycle later at pixel X=0, Y=0, tap 0.
- R2: While `op` is high, `coef_addr` starts at 0 and steps by one each cycle up to 8. `op` stays high for exactly 9 consecutive cycles per output pixel.
- R3: In tap k (0 to 8) of output pixel (X,Y), `mem_x` = clamp(X + (k mod 3) - 1) and `mem_y` = clamp(Y + (k div 3) - 1). The clamp maps values below 0 to 0 and values above 15 to 15.
- R4: Output pixels are visited with Y incrementing by one per pixel. When Y wraps from 15 to 0, X increments by one. The order runs from (0,0) to (15,15).
- R5: After tap 8, `op` stays low until a cycle in which `fb_rdy` and `fb_set` are both high, and it rises on the following cycle. Either line high on its own has no effect. Feedback seen while `op` is high has no effect on the tap sequence.
- R6: `op` is low for at least one cycle between two output pixels, even when feedback is held high throughout.
- R7: Once the feedback for pixel (15,15) is accepted, `done` rises and `op` stays low. `done` holds while `conv_en` stays high, whatever the feedback does, and clears when `conv_en` goes low.
- R8: A synchronous active-high `rst` forces `op` low, `done` low and `coef_addr` to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_en | input | 1 | Mode: 1 runs the convolution, 0 leaves the buffer to be loaded |
| fb_rdy | input | 1 | Ready feedback from the arithmetic unit |
| fb_set | input | 1 | Set feedback from the arithmetic unit |
| op | output | 1 | Operate strobe: the arithmetic unit accumulates while high |
| coef_addr | output | CW (4) | Kernel ROM address, 0 to 8 |
| mem_x | output | AW (4) | Pixel buffer X read address |
| mem_y | output | AW (4) | Pixel buffer Y read address |
| done | output | 1 | Whole frame finished |

## Verification
The bench sweeps a full frame with varying feedback latency and checks every tap address. This exercises all four borders and the corners, where a wrong clamp would wrap an address to the far side of the image. It also covers the Y-to-X carry, where an off-by-one counter would skip or repeat a row. Feedback is offered one line at a time, and is also held high through a whole pixel. A design that accepted either line alone, or re-armed without a low gap, would then start early or merge two pixels into one strobe. The bench also aborts in the middle of a pixel and holds feedback after the last pixel, to catch counters that survive a mode drop and a done flag that leaks back into running.

// File: rtl/conv_addr_seq.sv
module conv_addr_seq #(
  parameter int AW = 4,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          conv_en,
  input  logic          fb_rdy,
  input  logic          fb_set,
  output logic          op,
  output logic [CW-1:0] coef_addr,
  output logic [AW-1:0] mem_x,
  output logic [AW-1:0] mem_y,
  output logic          done
);
  localparam logic [CW-1:0] LAST_TAP = CW'(8);
  localparam logic [AW-1:0] LAST_POS = '1;
  localparam logic [AW:0]   HI_EDGE  = {1'b0, LAST_POS} + 1'b1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] tap;
  logic [AW-1:0] px, py;
  logic          waiting;

  always_ff @(posedge clk) begin
    if (rst || !conv_en) begin
      st  <= S_IDLE;
      tap <= '0;
      px  <= '0;
      py  <= '0;
    end else begin
      case (st)
        S_IDLE: st <= S_RUN;
        S_RUN: begin
          if (tap == LAST_TAP) begin
            st  <= S_WAIT;
            tap <= '0;
          end else begin
            tap <= tap + 1'b1;
          end
        end
        S_WAIT: begin
          if (fb_rdy && fb_set) begin
            if (px == LAST_POS && py == LAST_POS) begin
              st <= S_DONE;
            end else begin
              st <= S_RUN;
              py <= py + 1'b1;
              if (py == LAST_POS) px <= px + 1'b1;
            end
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end

  logic [CW-1:0] col, row;
  logic [AW:0]   tx, ty, tx_m1, ty_m1;

  assign col   = tap % CW'(3);
  assign row   = tap / CW'(3);
  assign tx    = {1'b0, px} + (AW+1)'(col[1:0]);
  assign ty    = {1'b0, py} + (AW+1)'(row[1:0]);
  assign tx_m1 = tx - 1'b1;
  assign ty_m1 = ty - 1'b1;

  assign mem_x = (tx == '0) ? '0 : (tx > HI_EDGE) ? LAST_POS : tx_m1[AW-1:0];
  assign mem_y = (ty == '0) ? '0 : (ty > HI_EDGE) ? LAST_POS : ty_m1[AW-1:0];

  assign op        = (st == S_RUN);
  assign done      = (st == S_DONE);
  assign waiting   = (st == S_WAIT);
  assign coef_addr = tap;
endmodule

module conv_addr_seq_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          conv_en,
  input logic          fb_rdy,
  input logic          fb_set,
  input logic          op,
  input logic          done,
  input logic [CW-1:0] coef_addr,
  input logic          waiting
);
  p_mode_low_r1: assert property (@(posedge clk) disable iff (rst)
    !conv_en |=> (!op && !done));

  p_coef_range_r2: assert property (@(posedge clk) disable iff (rst)
    op |-> (coef_addr < CW'(9)));

  p_coef_step_r2: assert property (@(posedge clk) disable iff (rst)
    (op && conv_en && coef_addr != CW'(8)) |=> (op && coef_addr == $past(coef_addr) + CW'(1)));

  p_op_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (op && coef_addr == CW'(8)) |=> !op);

  p_wait_feedback_r5: assert property (@(posedge clk) disable iff (rst)
    (waiting && !(fb_rdy && fb_set)) |=> !op);

  p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (done && conv_en) |=> (done && !op));

  p_reset_r8: assert property (@(posedge clk)
    rst |=> (!op && !done && coef_addr == '0));
endmodule

bind conv_addr_seq conv_addr_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .conv_en(conv_en), .fb_rdy(fb_rdy), .fb_set(fb_set),
  .op(op), .done(done), .coef_addr(coef_addr), .waiting(waiting)
);

// File: tb/tb_conv_addr_seq.sv
module tb_conv_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_en = 1'b0;
  logic       fb_rdy = 1'b0;
  logic       fb_set = 1'b0;
  logic       op, done;
  logic [3:0] coef_addr, mem_x, mem_y;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  conv_addr_seq dut (
    .clk(clk), .rst(rst), .conv_en(conv_en), .fb_rdy(fb_rdy), .fb_set(fb_set),
    .op(op), .coef_addr(coef_addr), .mem_x(mem_x), .mem_y(mem_y), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int clampc(input int v);
    return (v < 0) ? 0 : (v > 15) ? 15 : v;
  endfunction

  // At entry: at a negedge where tap 0 of pixel (ex,ey) should be showing.
  task automatic run_pixel(input int ex, input int ey, input int lat, input bit hold_fb);
    if (hold_fb) begin fb_rdy = 1'b1; fb_set = 1'b1; end
    for (int k = 0; k < 9; k++) begin
      int xe, ye, act, exp;
      xe  = clampc(ex + (k % 3) - 1);
      ye  = clampc(ey + (k / 3) - 1);
      act = {op, coef_addr, mem_x, mem_y};
      exp = {1'b1, 4'(k), 4'(xe), 4'(ye)};
      chk(act == exp, "R2/R3/R4 tap", act, exp);
      @(negedge clk);
    end
    chk(op == 1'b0, "R6 op low after tap 8", op, 0);
    if (!hold_fb) begin
      for (int i = 0; i < lat; i++) begin
        fb_rdy = (i % 2 == 0);
        fb_set = (i % 2 == 1);
        @(negedge clk);
        chk(op == 1'b0, "R5 partial feedback ignored", op, 0);
      end
    end
    fb_rdy = 1'b1; fb_set = 1'b1;
    @(negedge clk);
    fb_rdy = 1'b0; fb_set = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; conv_en = 1'b1;
    repeat (3) @(negedge clk);
    chk({op, done, coef_addr} == 6'b0, "R8 reset state", {op, done, coef_addr}, 0);
    conv_en = 1'b0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 6; i++) begin
      fb_rdy = i[0]; fb_set = i[1];
      @(negedge clk);
      chk({op, done} == 2'b0, "R1 idle while mode low", {op, done}, 0);
    end
    fb_rdy = 1'b0; fb_set = 1'b0;
  endtask

  task automatic t_frame();
    conv_en = 1'b1;
    @(negedge clk);
    chk(op == 1'b1, "R1 op rises one cycle after mode", op, 1);
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        run_pixel(x, y, (x * 16 + y) % 4, (x * 16 + y) == 5 || (x * 16 + y) == 200);
    chk({done, op} == 2'b10, "R7 done after last pixel", {done, op}, 2);
    fb_rdy = 1'b1; fb_set = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk({done, op} == 2'b10, "R7 done holds with feedback", {done, op}, 2);
    end
    fb_rdy = 1'b0; fb_set = 1'b0;
    conv_en = 1'b0;
    @(negedge clk);
    chk({done, op} == 2'b00, "R7 done clears on mode low", {done, op}, 0);
  endtask

  task automatic t_abort();
    conv_en = 1'b1;
    @(negedge clk);
    run_pixel(0, 0, 1, 1'b0);
    repeat (3) @(negedge clk);
    chk(coef_addr == 4'd3 && op, "R2 mid pixel tap", coef_addr, 3);
    conv_en = 1'b0;
    @(negedge clk);
    chk({op, coef_addr} == 5'b0, "R1 abort clears", {op, coef_addr}, 0);
    conv_en = 1'b1;
    @(negedge clk);
    run_pixel(0, 0, 2, 1'b0);
    run_pixel(0, 1, 0, 1'b0);
    conv_en = 1'b0;
    @(negedge clk);
    chk(op == 1'b0, "R1 op low after mode low", op, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_frame();
    t_abort();
    t_reset();
    summary();
  end
endmodule